// File: doc/BRIEF.md
# Byte Zap/Extract/Insert Unit

This execution unit performs the byte-granular data movement operations of a 64-bit integer pipeline. Every operation is expressed as one byte-select value, expanded to a full-width mask, combined with a shift by a whole number of bytes. Clearing or keeping chosen bytes ("zap" and "zap-not") uses the mask alone. Inserting a small field at a byte offset masks first and then shifts left. Extracting a field shifts first and then masks: low extraction shifts right, high extraction shifts left.

The second operand is either a full register value or an 8-bit literal, chosen by a flag. Two more flags say whether the first source or the destination is the hardwired-zero register. The unit takes one request per clock under `in_valid`. One cycle later it presents a registered result with a write-enable and a flag for undecodable function codes.

Top module: `byte_shuffle_unit`

## Requirements
- R1: Byte-select bit i governs byte lane i, which is bits 8i+7..8i of the data. The 64-bit mask is the 8-bit select with each bit widened to a whole byte.
- R2: Function 0x31 (keep) returns operand A with every byte whose select bit is 1 kept and every other byte cleared. The select is the low 8 bits of the effective B operand. Select 0x00 gives zero and 0xFF gives A unchanged.
- R3: Function 0x30 (clear) returns A with every byte whose select bit is 1 cleared, which is the R2 operation applied to the inverted select.
- R4: Insert-low functions 0x0B, 0x1B, 0x2B and 0x3B use field sizes of 1, 2, 4 and 8 bytes (size masks 0x01, 0x03, 0x0F, 0xFF). Each one masks A to its field size and then shifts the result left by 8*k bits.
- R5: Extract-low functions 0x06, 0x16, 0x26 and 0x36 use the same four sizes. Each one shifts A right by 8*k bits and then masks the result to its field size.
- R6: Extract-high functions 0x5A, 0x6A and 0x7A use sizes of 2, 4 and 8 bytes. Each one shifts A left by (64 - 8*k) mod 64 bits and then masks the result to its field size, so an offset of k = 0 shifts by zero.
- R7: The byte offset k is the low 3 bits of the effective B operand. When `use_lit` is 1, the effective B operand is `lit` zero-extended. Otherwise it is `opb`, and the upper bits of `opb` have no effect on the result.
- R8: When `rc_zero` is 1, `out_we` is 0 for that request.
- R9: When `ra_zero` is 1, `out_result` is zero for every function. `out_we` is then 1 only if the function is legal and `rc_zero` is 0.
- R10: `out_valid` equals `in_valid` of the previous cycle. A synchronous reset clears `out_valid`, `out_we`, `out_illegal` and `out_result`.
- R11: Any function code outside the 13 listed in R2-R6 gives `out_illegal` = 1, `out_we` = 0 and a zero result in the result cycle.
- R12: In a cycle following `in_valid` = 0, `out_we` and `out_illegal` are 0 and `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| func | input | 7 | Function code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Register form of operand B |
| lit | input | 8 | Literal form of operand B |
| use_lit | input | 1 | 1 selects `lit` as operand B |
| ra_zero | input | 1 | Source A is the zero register |
| rc_zero | input | 1 | Destination is the zero register |
| out_valid | output | 1 | Registered result present |
| out_result | output | 64 | Registered result |
| out_we | output | 1 | Write the result to the destination |
| out_illegal | output | 1 | Function code not recognised |

## Verification
On every cycle, the embedded properties check the handshake timing, the write suppression for a zero destination, the zero result for a zero source, and the rule that an illegal code never writes. They also check that idle cycles stay quiet and that the expanded mask carries exactly eight bits per selected lane. The data values themselves need the bench's sweeps. These sweeps cover all 256 select values for both zap forms, every offset for every insert and extract size in both literal and register form, and every one of the 128 function codes for legality. Only these scenarios show that the mask is applied before the shift for inserts and after it for extracts, and that the high extract wraps at an offset of zero.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
   localparam int FUNC_W = 7;

   typedef enum logic [2:0] {
      OPK_NONE   = 3'd0,
      OPK_KEEP   = 3'd1,
      OPK_CLEAR  = 3'd2,
      OPK_INSERT = 3'd3,
      OPK_EXT_LO = 3'd4,
      OPK_EXT_HI = 3'd5
   } op_kind_e;

   localparam logic [FUNC_W-1:0] FN_CLEAR = 7'h30;
   localparam logic [FUNC_W-1:0] FN_KEEP  = 7'h31;
   localparam logic [3:0] LOW_NIB_INSERT = 4'hB;
   localparam logic [3:0] LOW_NIB_EXT_LO = 4'h6;
   localparam logic [3:0] LOW_NIB_EXT_HI = 4'hA;
endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
   import bsu_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic [FUNC_W-1:0] func_i,
   output op_kind_e          kind_o,
   output logic [LANES-1:0]  size_sel_o,
   output logic              legal_o
);
   logic [1:0] size_code;
   int unsigned field_bytes;

   assign size_code   = func_i[5:4];
   assign field_bytes = 32'd1 << size_code;

   always_comb begin
      kind_o = OPK_NONE;
      if (func_i == FN_CLEAR)
         kind_o = OPK_CLEAR;
      else if (func_i == FN_KEEP)
         kind_o = OPK_KEEP;
      else if (!func_i[6] && func_i[3:0] == LOW_NIB_INSERT)
         kind_o = OPK_INSERT;
      else if (!func_i[6] && func_i[3:0] == LOW_NIB_EXT_LO)
         kind_o = OPK_EXT_LO;
      else if (func_i[6] && func_i[3:0] == LOW_NIB_EXT_HI && size_code != 2'd0)
         kind_o = OPK_EXT_HI;
   end

   assign legal_o = (kind_o != OPK_NONE);

   always_comb begin
      for (int i = 0; i < LANES; i++)
         size_sel_o[i] = (i < int'(field_bytes));
   end
endmodule

// File: rtl/bsu_mask_expand.sv
module bsu_mask_expand #(
   parameter int LANES  = 8,
   parameter int DATA_W = LANES * 8
) (
   input  logic [LANES-1:0]  sel_i,
   output logic [DATA_W-1:0] mask_o
);
   if (DATA_W != LANES * 8) begin : g_bad_width
      $error("bsu_mask_expand: DATA_W must be 8*LANES");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign mask_o[8*g +: 8] = {8{sel_i[g]}};
   end

   always_comb begin
      if (!$isunknown(sel_i))
         a_r1_lane_bits : assert ($countones(mask_o) == 8 * $countones(sel_i));
   end
endmodule

// File: rtl/bsu_lane_shifter.sv
module bsu_lane_shifter #(
   parameter int DATA_W     = 64,
   parameter int LANES      = DATA_W / 8,
   parameter int SEL_W      = $clog2(LANES),
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [SEL_W-1:0]  amt_i,
   input  logic              left_i,
   output logic [DATA_W-1:0] data_o
);
   if (LOG_STAGES) begin : g_staged
      logic [DATA_W-1:0] stage [0:SEL_W];
      assign stage[0] = data_i;
      for (genvar s = 0; s < SEL_W; s++) begin : g_stage
         localparam int STEP = 8 << s;
         assign stage[s+1] = !amt_i[s] ? stage[s] :
                             left_i    ? (stage[s] << STEP) : (stage[s] >> STEP);
      end
      assign data_o = stage[SEL_W];
   end else begin : g_flat
      logic [SEL_W+2:0] bit_amt;
      assign bit_amt = {amt_i, 3'b000};
      assign data_o  = left_i ? (data_i << bit_amt) : (data_i >> bit_amt);
   end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
   import bsu_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int LIT_W      = 8,
   parameter bit LOG_STAGES = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [6:0]        func,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [LIT_W-1:0]  lit,
   input  logic              use_lit,
   input  logic              ra_zero,
   input  logic              rc_zero,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result,
   output logic              out_we,
   output logic              out_illegal
);
   localparam int LANES = DATA_W / 8;
   localparam int SEL_W = $clog2(LANES);

   if (DATA_W % 8 != 0 || (1 << SEL_W) != LANES) begin : g_chk_width
      $error("byte_shuffle_unit: DATA_W must be 8 times a power of two");
   end
   if (LIT_W < LANES || LIT_W > DATA_W) begin : g_chk_lit
      $error("byte_shuffle_unit: LIT_W must cover one select bit per lane");
   end

   logic [DATA_W-1:0] b_eff;
   logic [SEL_W-1:0]  offset;
   logic [LANES-1:0]  b_sel, size_sel, pre_sel, post_sel;
   logic [DATA_W-1:0] pre_mask, post_mask, shifted, result_c;
   logic [SEL_W-1:0]  shift_amt;
   logic              shift_left, legal;
   op_kind_e          kind;

   assign b_eff  = use_lit ? DATA_W'(lit) : opb;
   assign offset = b_eff[SEL_W-1:0];
   assign b_sel  = b_eff[LANES-1:0];

   bsu_decode #(.LANES(LANES)) u_dec (
      .func_i     (func),
      .kind_o     (kind),
      .size_sel_o (size_sel),
      .legal_o    (legal)
   );

   always_comb begin
      pre_sel    = '1;
      post_sel   = '1;
      shift_amt  = '0;
      shift_left = 1'b0;
      unique case (kind)
         OPK_KEEP:   pre_sel = b_sel;
         OPK_CLEAR:  pre_sel = ~b_sel;
         OPK_INSERT: begin
            pre_sel    = size_sel;
            shift_amt  = offset;
            shift_left = 1'b1;
         end
         OPK_EXT_LO: begin
            post_sel  = size_sel;
            shift_amt = offset;
         end
         OPK_EXT_HI: begin
            post_sel   = size_sel;
            shift_amt  = SEL_W'(0) - offset;
            shift_left = 1'b1;
         end
         default: ;
      endcase
   end

   bsu_mask_expand #(.LANES(LANES), .DATA_W(DATA_W)) u_pre_mask (
      .sel_i  (pre_sel),
      .mask_o (pre_mask)
   );

   bsu_mask_expand #(.LANES(LANES), .DATA_W(DATA_W)) u_post_mask (
      .sel_i  (post_sel),
      .mask_o (post_mask)
   );

   bsu_lane_shifter #(
      .DATA_W     (DATA_W),
      .LANES      (LANES),
      .SEL_W      (SEL_W),
      .LOG_STAGES (LOG_STAGES)
   ) u_shift (
      .data_i (opa & pre_mask),
      .amt_i  (shift_amt),
      .left_i (shift_left),
      .data_o (shifted)
   );

   assign result_c = (ra_zero || !legal) ? '0 : (shifted & post_mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_we      <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= result_c;
            out_we      <= legal && !rc_zero;
            out_illegal <= !legal;
         end else begin
            out_we      <= 1'b0;
            out_illegal <= 1'b0;
         end
      end
   end

   a_r10_valid_follows : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r10_idle_follows : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   a_r8_no_write_zero_dest : assert property (@(posedge clk) disable iff (rst)
      (in_valid && rc_zero) |=> !out_we);
   a_r9_zero_source : assert property (@(posedge clk) disable iff (rst)
      (in_valid && ra_zero) |=> (out_result == '0));
   a_r11_illegal_no_write : assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (!out_we && out_result == '0));
   a_r12_idle_quiet : assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!out_we && !out_illegal));
   a_r12_idle_holds : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_result));
endmodule

// File: tb/byte_shuffle_unit_test.sv
module byte_shuffle_unit_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [6:0]  func;
   logic [63:0] opa, opb;
   logic [7:0]  lit;
   logic        use_lit, ra_zero, rc_zero;
   logic        out_valid, out_we, out_illegal;
   logic [63:0] out_result;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   byte_shuffle_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
      .opa(opa), .opb(opb), .lit(lit), .use_lit(use_lit),
      .ra_zero(ra_zero), .rc_zero(rc_zero),
      .out_valid(out_valid), .out_result(out_result),
      .out_we(out_we), .out_illegal(out_illegal)
   );

   function automatic bit is_legal(input logic [6:0] f);
      case (f)
         7'h30, 7'h31, 7'h0B, 7'h1B, 7'h2B, 7'h3B,
         7'h06, 7'h16, 7'h26, 7'h36, 7'h5A, 7'h6A, 7'h7A: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [63:0] model(input logic [6:0] f,
                                         input logic [63:0] a,
                                         input logic [63:0] b);
      logic [63:0] r = '0;
      int k = int'(b[2:0]);
      int nb = 1 << f[5:4];
      int s = (8 - k) % 8;
      for (int j = 0; j < 8; j++) begin
         if (f == 7'h31 && b[j])            r[8*j +: 8] = a[8*j +: 8];
         else if (f == 7'h30 && !b[j])      r[8*j +: 8] = a[8*j +: 8];
         else if (f[3:0] == 4'hB && f[6] == 1'b0) begin
            if (j >= k && (j - k) < nb)     r[8*j +: 8] = a[8*(j-k) +: 8];
         end else if (f[3:0] == 4'h6 && f[6] == 1'b0) begin
            if (j + k < 8 && j < nb)        r[8*j +: 8] = a[8*(j+k) +: 8];
         end else if (f[3:0] == 4'hA && f[6] == 1'b1) begin
            if (j >= s && j < nb)           r[8*j +: 8] = a[8*(j-s) +: 8];
         end
      end
      if (!is_legal(f)) r = '0;
      return r;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic run(input logic [6:0] f, input logic [63:0] a,
                      input logic [63:0] b, input bit ul, input bit raz,
                      input bit rcz, input string req);
      logic [63:0] beff, exp_r;
      bit legal;
      in_valid = 1'b1; func = f; opa = a; use_lit = ul;
      ra_zero = raz; rc_zero = rcz;
      if (ul) begin lit = b[7:0]; opb = 64'hDEAD_BEEF_0BAD_F00D; end
      else    begin lit = 8'hA5;  opb = b; end
      beff  = ul ? {56'h0, b[7:0]} : b;
      legal = is_legal(f);
      exp_r = raz ? 64'h0 : model(f, a, beff);
      @(negedge clk);
      check(out_valid && out_result == exp_r, req, out_result, exp_r);
      check(out_we == (legal && !rcz) && out_illegal == !legal,
            {req, " we/illegal"}, {62'h0, out_we, out_illegal},
            {62'h0, legal && !rcz, !legal});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   localparam logic [63:0] A0 = 64'h8877_6655_4433_2211;
   localparam logic [63:0] A1 = 64'hF0E1_D2C3_B4A5_9687;

   initial begin
      logic [63:0] held;
      rst = 1'b1; in_valid = 1'b0; func = '0; opa = '0; opb = '0;
      lit = '0; use_lit = 1'b0; ra_zero = 1'b0; rc_zero = 1'b0;
      repeat (3) @(negedge clk);
      check(!out_valid && !out_we && !out_illegal && out_result == 0,
            "R10 reset state", {61'h0, out_valid, out_we, out_illegal}, 0);
      rst = 1'b0;

      // R1 R2 R3: every select value for keep and clear
      for (int s = 0; s < 256; s++) begin
         run(7'h31, A0, {56'h5A5A5A_5A5A5A5, 8'(s)}, s[0], 1'b0, 1'b0, "R1 R2 keep");
         run(7'h30, A1, {56'h0, 8'(s)}, ~s[0], 1'b0, 1'b0, "R3 clear");
      end

      // R4 R5 R6 R7: all sizes and offsets, literal and register B
      for (int k = 0; k < 8; k++) begin
         for (int sz = 0; sz < 4; sz++) begin
            run({1'b0, 2'(sz), 4'hB}, A0, 64'h1234_5678_9ABC_DE00 | 64'(k), 1'b0, 1'b0, 1'b0, "R4 R7 insert reg");
            run({1'b0, 2'(sz), 4'hB}, A1, 64'(8'hF8 | k), 1'b1, 1'b0, 1'b0, "R4 R7 insert lit");
            run({1'b0, 2'(sz), 4'h6}, A1, 64'hFFFF_0000_FFFF_FF00 | 64'(k), 1'b0, 1'b0, 1'b0, "R5 R7 extract low reg");
            run({1'b0, 2'(sz), 4'h6}, A0, 64'(8'h30 | k), 1'b1, 1'b0, 1'b0, "R5 R7 extract low lit");
            if (sz != 0) begin
               run({1'b1, 2'(sz), 4'hA}, A0, 64'h0F0F_0F0F_0F0F_0F08 | 64'(k), 1'b0, 1'b0, 1'b0, "R6 R7 extract high reg");
               run({1'b1, 2'(sz), 4'hA}, A1, 64'(8'hC0 | k), 1'b1, 1'b0, 1'b0, "R6 R7 extract high lit");
            end
         end
      end

      // R8 R9: zero destination and zero source
      run(7'h31, A0, 64'hFF, 1'b1, 1'b0, 1'b1, "R8 zero dest keep");
      run(7'h1B, A1, 64'h3, 1'b0, 1'b0, 1'b1, "R8 zero dest insert");
      run(7'h31, A0, 64'hFF, 1'b1, 1'b1, 1'b0, "R9 zero source keep");
      run(7'h7A, A1, 64'h5, 1'b0, 1'b1, 1'b0, "R9 zero source extract");
      run(7'h30, A1, 64'h0, 1'b1, 1'b1, 1'b1, "R8 R9 both zero");

      // R11: every function code
      for (int f = 0; f < 128; f++)
         run(7'(f), A1, 64'h0000_0000_0000_0F03, 1'b0, 1'b0, 1'b0, "R11 code sweep");
      run(7'h4A, A0, 64'h1, 1'b0, 1'b0, 1'b0, "R11 extract high byte size illegal");

      // R12 R10: idle cycles keep the result and stay quiet
      held = out_result;
      in_valid = 1'b0; func = 7'h31; opa = A0; lit = 8'hFF; use_lit = 1'b1;
      @(negedge clk);
      check(!out_valid, "R10 valid drops", {63'h0, out_valid}, 0);
      check(!out_we && !out_illegal && out_result == held, "R12 idle hold",
            out_result, held);
      func = 7'h7F;
      @(negedge clk);
      check(!out_we && !out_illegal && out_result == held, "R12 idle illegal ignored",
            out_result, held);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule